// File: doc/BRIEF.md
# Multi-digit BCD Parallel Adder

This block adds two packed binary-coded-decimal operands of `DIGITS` decimal digits each, together with a single carry-in bit. It returns a packed BCD sum of the same width and a decimal carry-out. The digits are handled in parallel, one stage per digit. Each stage first forms the plain 4-bit binary sum of its two digits and its incoming carry. That adder builds its internal carries by lookahead from generate and propagate terms. The stage then checks whether this raw result has left the decimal range. When it has, a second lookahead adder adds six, and the stage raises its decimal carry.

The decimal carry of each stage is the carry-in of the next more significant stage. The whole digit chain is combinational. A single output register stage captures the sum and the final carry on each rising clock edge, so the result of the operands applied before an edge appears after that edge. Operands are assumed to hold valid BCD digits (0 to 9 each). Values above nine are outside the contract.

Top module: `bcd_par_adder`

## Requirements
- R1: The outputs are registered. The result for the operands and carry-in present at a rising clock edge is visible after that edge. While the active-low reset is low, the sum and the carry-out are zero.
- R2: Digit k of each packed operand and of the sum occupies bits [4k+3:4k], so digit 0 (the units) sits in bits [3:0].
- R3: For valid BCD operands, every 4-bit digit of the registered sum holds a value from 0 to 9.
- R4: In a single digit position, a raw binary total from 0 to 9 passes through unchanged with no decimal carry. A total from 10 to 19 becomes total minus ten, with a decimal carry of 1. All 200 single-digit cases are covered (each digit 0 to 9, carry-in 0 or 1).
- R5: The decimal carry of each digit feeds the digit above it, so a carry ripples across consecutive nines. For example, all-nines plus zero with carry-in 1 gives all zeros and carry-out 1.
- R6: The carry-out is 1 exactly when the decimal total of both operands plus carry-in is at least 10^DIGITS.
- R7: A carry-in of 1 adds exactly one to the decimal total. With both operands zero, the sum reads 1 in digit 0.
- R8: The packed sum equals (A + B + carry-in) modulo 10^DIGITS, where A and B are the decimal values of the operands.
- R9: Bit 0 of the sum equals the XOR of bit 0 of both operands and the carry-in, because the correction of six never changes the least significant bit.
- R10: When every operand digit is 4 or less, no digit produces a decimal carry, and the carry-out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 4*DIGITS | First packed BCD operand |
| b_i | input | 4*DIGITS | Second packed BCD operand |
| cin_i | input | 1 | Carry into digit 0 |
| sum_o | output | 4*DIGITS | Registered packed BCD sum |
| cout_o | output | 1 | Registered decimal carry out of the top digit |

## Verification
The assertions check several properties on every clock edge, each comparing the registered outputs with the inputs of the previous cycle:
- every output digit stays in the decimal range;
- the least significant sum bit follows the parity of the lowest operand bits and the carry-in;
- zero operands give zero, or one when the carry-in is set;
- small digits never generate a carry;
- the outputs stay cleared during reset.

The scenarios are needed for the rest. The exact correction of every one of the 200 single-digit cases, carries rippling through runs of nines, the exact threshold at which the carry-out is set, and full agreement with an integer decimal model are shown only by the bench's directed and random operands.

// File: rtl/bcd_par_adder.sv
module bcd_par_adder #(
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*DIGITS-1:0]   a_i,
  input  logic [4*DIGITS-1:0]   b_i,
  input  logic                  cin_i,
  output logic [4*DIGITS-1:0]   sum_o,
  output logic                  cout_o
);
  localparam int W = 4 * DIGITS;

  // lookahead 4-bit add with carry out
  function automatic logic [4:0] la_add(input logic [3:0] x, input logic [3:0] y, input logic c0);
    logic [3:0] g, p;
    logic c1, c2, c3, c4;
    g  = x & y;
    p  = x ^ y;
    c1 = g[0] | (p[0] & c0);
    c2 = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c3 = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
    c4 = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
       | (p[3] & p[2] & p[1] & p[0] & c0);
    return {c4, p ^ {c3, c2, c1, c0}};
  endfunction

  // lookahead 4-bit add, sum bits only
  function automatic logic [3:0] la_sum(input logic [3:0] x, input logic [3:0] y);
    logic [3:0] g, p;
    logic c1, c2, c3;
    g  = x & y;
    p  = x ^ y;
    c1 = g[0];
    c2 = g[1] | (p[1] & g[0]);
    c3 = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]);
    return p ^ {c3, c2, c1, 1'b0};
  endfunction

  logic [DIGITS:0] dcar;
  logic [W-1:0]    sum_d;

  assign dcar[0] = cin_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    logic [4:0] raw;
    logic [3:0] z;
    logic       fix;

    assign raw         = la_add(a_i[4*k +: 4], b_i[4*k +: 4], dcar[k]);
    assign z           = raw[3:0];
    assign fix         = raw[4] | (z[3] & z[2]) | (z[3] & z[1]);
    assign dcar[k+1]   = fix;
    assign sum_d[4*k +: 4] = la_sum(z, {1'b0, fix, fix, 1'b0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_d;
      cout_o <= dcar[DIGITS];
    end
  end
endmodule

// File: rtl/bcd_par_adder_chk.sv
module bcd_par_adder_chk #(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [4*DIGITS-1:0] a_i,
  input logic [4*DIGITS-1:0] b_i,
  input logic                cin_i,
  input logic [4*DIGITS-1:0] sum_o,
  input logic                cout_o
);
  localparam int W = 4 * DIGITS;

  function automatic logic all_le(input logic [W-1:0] v, input logic [3:0] lim);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) if (v[4*k +: 4] > lim) ok = 1'b0;
    return ok;
  endfunction

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (sum_o == '0 && !cout_o));

  // R3
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (all_le($past(a_i), 4'd9) && all_le($past(b_i), 4'd9)) |-> all_le(sum_o, 4'd9));

  // R9
  lsb_parity_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    1'b1 |-> (sum_o[0] == ($past(a_i[0]) ^ $past(b_i[0]) ^ $past(cin_i))));

  // R7
  zero_operands_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(a_i) == '0 && $past(b_i) == '0) |->
      (sum_o == W'($past(cin_i)) && !cout_o));

  // R10
  small_digits_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (all_le($past(a_i), 4'd4) && all_le($past(b_i), 4'd4)) |-> !cout_o);
endmodule

bind bcd_par_adder bcd_par_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/sim_bcd_par_adder.sv
module sim_bcd_par_adder;
  localparam int  N      = 4;
  localparam int  W      = 4 * N;
  localparam int  MODV   = 10 ** N;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W:0] exp_q[$];
  string      tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  bcd_par_adder #(.DIGITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  function automatic int to_int(input logic [W-1:0] v);
    int r = 0;
    for (int k = N - 1; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] to_bcd(input int x);
    logic [W-1:0] r = '0;
    int t = x;
    for (int k = 0; k < N; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv, input string tag);
    int tot;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    tot = to_int(av) + to_int(bv) + int'(cv);
    exp_q.push_back({tot >= MODV, to_bcd(tot % MODV)});
    tag_q.push_back(tag);
  endtask

  // monitor: result registered at the edge after the drive (R1)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && exp_q.size() > 0) begin
        logic [W:0] e;
        string t;
        bit okd;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({cout, sum} !== e) begin
          errors++;
          $display("FAIL %s: got cout=%b sum=%h, expected cout=%b sum=%h", t, cout, sum, e[W], e[W-1:0]);
        end
        okd = 1;
        for (int k = 0; k < N; k++) if (sum[4*k +: 4] > 4'd9) okd = 0;
        checks++;
        if (!okd) begin
          errors++;
          $display("FAIL R3: got sum=%h, expected every digit <= 9", sum);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: got no completion, expected run to end");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    a = 16'h9999; b = 16'h9999; cin = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (sum !== '0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL R1: got cout=%b sum=%h under reset, expected 0/0000", cout, sum);
    end
    rst_n = 1'b1;

    // R4: every single-digit case
    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        for (int c = 0; c < 2; c++)
          drive(W'(x), W'(y), c[0], "R4");

    drive(16'h0007, 16'h0300, 1'b0, "R2");
    drive(16'h0040, 16'h0005, 1'b0, "R2");
    drive(16'h9999, 16'h0000, 1'b1, "R5");
    drive(16'h9999, 16'h9999, 1'b1, "R5");
    drive(16'h0999, 16'h0001, 1'b0, "R5");
    drive(16'h5000, 16'h5000, 1'b0, "R6");
    drive(16'h4999, 16'h5000, 1'b0, "R6");
    drive(16'h4999, 16'h5000, 1'b1, "R6");
    drive(16'h0000, 16'h0000, 1'b1, "R7");
    drive(16'h1234, 16'h1234, 1'b1, "R7");
    drive(16'h0005, 16'h0004, 1'b1, "R9");
    drive(16'h4444, 16'h4444, 1'b1, "R10");

    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] ra, rb;
      for (int k = 0; k < N; k++) begin
        ra[4*k +: 4] = 4'($urandom_range(9));
        rb[4*k +: 4] = 4'($urandom_range(9));
      end
      drive(ra, rb, 1'($urandom_range(1)), "R8");
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule